// File: doc/BRIEF.md
# Locked Read-Modify-Write Sequencer

This block sets the order of the steps in an atomic read-modify-write that a processor core issues on its external bus. A locked request arrives with the result of the cache lookup. The sequencer first waits until every buffered write has left the bus. It then either copies a modified line back and invalidates it, only invalidates a clean line, or goes straight on after a miss. Next it runs the locked read and waits for the core to say the modified data is ready. Last it runs the locked write. Each of these steps is a command to the bus master: copy back, invalidate, read or write. The bus master returns single-beat and burst-beat ready strobes.

While the lock is held, the block ignores bus-hold requests. Back-off aborts and replays the bus cycle in flight. Address hold stops the sequence from starting its next step. An external snoop write-back may slip in between the locked read and the locked write without breaking the lock. A busy output keeps all later core accesses stalled until the cycle after the final ready. In write-through mode a second, active-low lock indicator follows the lock. In write-back mode that indicator stays inactive.

Top module: `locked_rmw_seq`

## Requirements
- R1: After reset the block issues no command, `bus_lock` is low, `mc_lock_n` is high, `hold_ack`, `busy` and `seq_done` are low.
- R2: After a request is accepted, no command is issued while `wbuf_empty` is low, and `busy` stays high meanwhile.
- R3: On a cache miss the commands are a locked READ (`cmd_op`=2) followed, once `wr_go` is seen, by a locked WRITE (`cmd_op`=3), with no invalidate or copy-back.
- R4: On a hit to a clean line, one INVALIDATE command (`cmd_op`=1, one cycle) comes before the locked READ. The external read is always performed.
- R5: On a hit to a modified line, a COPYBACK burst (`cmd_op`=0, `cmd_burst` high) of `LINE_BEATS` burst-ready beats comes first, then INVALIDATE, READ and WRITE. `bus_lock` is low during that copy-back.
- R6: `bus_lock` rises in the first cycle the locked READ command is shown. It stays high through the WRITE and falls in the cycle after the WRITE's final ready.
- R7: With `wt_mode` high, `mc_lock_n` is low exactly while `bus_lock` is high. With `wt_mode` low, `mc_lock_n` stays high.
- R8: While idle, `hold_ack` follows `hold_req` one clock later, and no request is accepted while `hold_ack` is high. During a sequence `hold_ack` stays low. A hold pending at release is granted one clock after `bus_lock` falls.
- R9: While `boff` is high, `cmd_valid` is low and ready strobes are ignored. Afterwards the interrupted command is reissued from its first beat, and the lock is kept.
- R10: While `ahold` is high, the sequence does not leave the drain step or the step between the read and the write.
- R11: A `snoop_wb` request between the locked read and the locked write issues a COPYBACK burst with `bus_lock` still high, and it takes priority over `wr_go`.
- R12: A single-beat command ends on either ready strobe. A burst command ends on its last burst-ready beat, or early on `bus_rdy`.
- R13: `busy` is high from the accepted request until the cycle after the final ready. `seq_done` pulses for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core requests a locked read-modify-write |
| lookup_hit | input | 1 | Cache lookup hit, sampled with the request |
| lookup_dirty | input | 1 | Hit line is modified, sampled with the request |
| wbuf_empty | input | 1 | Write buffer has drained to the bus |
| wr_go | input | 1 | Core has the modified data ready for the locked write |
| snoop_wb | input | 1 | External snoop needs a write-back inside the lock |
| bus_rdy | input | 1 | Single-beat ready, also ends a burst early |
| bus_brdy | input | 1 | Burst-beat ready |
| hold_req | input | 1 | Bus-hold request from another master |
| boff | input | 1 | Back-off: abort the current bus cycle |
| ahold | input | 1 | Address hold: do not start a new step |
| wt_mode | input | 1 | 1 = write-through cache mode |
| cmd_valid | output | 1 | A command is shown to the bus master |
| cmd_op | output | 2 | 0 copy-back, 1 invalidate, 2 read, 3 write |
| cmd_burst | output | 1 | Command is a line burst |
| bus_lock | output | 1 | Bus lock held |
| mc_lock_n | output | 1 | Active-low multi-cycle lock (write-through mode) |
| hold_ack | output | 1 | Bus-hold grant |
| busy | output | 1 | Stall later core accesses |
| seq_done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
The sequence runs after a miss, after a clean hit and after a dirty hit. Each case must give its own command order, which shows that the cache state is never used in place of the external read. The same sequence then runs with a write buffer that drains late, with hold raised both before and during the lock, with back-off raised in the middle of a copy-back burst, with address hold between the read and the write, and with a snoop write-back inside the lock that ends early on single-beat ready. These runs tell apart gating the lock from gating the steps, and replaying a burst from its first beat from resuming it in the middle. Write-through and write-back modes separate the two lock outputs.

// File: rtl/lrmw_pkg.sv
package lrmw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DRAIN  = 3'd1,
        ST_CPBK   = 3'd2,
        ST_INVAL  = 3'd3,
        ST_LREAD  = 3'd4,
        ST_MID    = 3'd5,
        ST_SNPWB  = 3'd6,
        ST_LWRITE = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_COPYBACK = 2'd0,
        OP_INVAL    = 2'd1,
        OP_READ     = 2'd2,
        OP_WRITE    = 2'd3
    } bus_op_e;

    typedef struct packed {
        seq_state_e state;
        logic       hit;
        logic       dirty;
        logic       done;
    } fsm_regs_t;

    typedef struct packed {
        logic lock;
        logic mcl_n;
        logic hold_ack;
    } lock_regs_t;

endpackage

// File: rtl/lrmw_beat_ctr.sv
module lrmw_beat_ctr #(
    parameter int LINE_BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic burst,
    input  logic rdy,
    input  logic brdy,
    output logic cyc_end
);
    localparam int CW = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
    localparam logic [CW-1:0] LAST = CW'(LINE_BEATS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } beat_regs_t;

    beat_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        cyc_end = active && (rdy || (brdy && (!burst || r_q.cnt == LAST)));
        if (!active || cyc_end) begin
            r_d.cnt = '0;
        end else if (brdy && burst) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST); // R5
    AST_BOFF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> r_q.cnt == '0); // R9

endmodule

// File: rtl/lrmw_fsm.sv
module lrmw_fsm
    import lrmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       lookup_hit,
    input  logic       lookup_dirty,
    input  logic       wbuf_empty,
    input  logic       wr_go,
    input  logic       snoop_wb,
    input  logic       boff,
    input  logic       ahold,
    input  logic       hold_ack_q,
    input  logic       cyc_end,
    output logic       cmd_valid,
    output logic [1:0] cmd_op,
    output logic       cmd_burst,
    output logic       bus_active,
    output logic       req_take,
    output logic       idle,
    output logic       lock_next,
    output logic       busy,
    output logic       done
);
    fsm_regs_t r_q, r_d;
    logic on_cmd;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        idle     = (r_q.state == ST_IDLE);
        req_take = idle && req_valid && !hold_ack_q;

        unique case (r_q.state)
            ST_IDLE: begin
                if (req_take) begin
                    r_d.state = ST_DRAIN;
                    r_d.hit   = lookup_hit;
                    r_d.dirty = lookup_dirty;
                end
            end
            ST_DRAIN: begin
                if (wbuf_empty && !ahold) begin
                    if (r_q.hit && r_q.dirty) r_d.state = ST_CPBK;
                    else if (r_q.hit)         r_d.state = ST_INVAL;
                    else                      r_d.state = ST_LREAD;
                end
            end
            ST_CPBK:   if (cyc_end) r_d.state = ST_INVAL;
            ST_INVAL:  if (!boff)   r_d.state = ST_LREAD;
            ST_LREAD:  if (cyc_end) r_d.state = ST_MID;
            ST_MID: begin
                if (!ahold) begin
                    if (snoop_wb)   r_d.state = ST_SNPWB;
                    else if (wr_go) r_d.state = ST_LWRITE;
                end
            end
            ST_SNPWB:  if (cyc_end) r_d.state = ST_MID;
            ST_LWRITE: begin
                if (cyc_end) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default:   r_d.state = ST_IDLE;
        endcase

        lock_next = (r_d.state == ST_LREAD) || (r_d.state == ST_MID) ||
                    (r_d.state == ST_SNPWB) || (r_d.state == ST_LWRITE);

        on_cmd = (r_q.state == ST_CPBK) || (r_q.state == ST_INVAL) ||
                 (r_q.state == ST_LREAD) || (r_q.state == ST_SNPWB) ||
                 (r_q.state == ST_LWRITE);
        cmd_valid  = on_cmd && !boff;
        bus_active = cmd_valid && (r_q.state != ST_INVAL);
        cmd_burst  = (r_q.state == ST_CPBK) || (r_q.state == ST_SNPWB);

        unique case (r_q.state)
            ST_INVAL:  cmd_op = OP_INVAL;
            ST_LREAD:  cmd_op = OP_READ;
            ST_LWRITE: cmd_op = OP_WRITE;
            default:   cmd_op = OP_COPYBACK;
        endcase

        busy = !idle;
        done = r_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, hit: 1'b0, dirty: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DRAIN && !wbuf_empty) |=> r_q.state == ST_DRAIN); // R2
    AST_AHOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_MID && ahold) |=> r_q.state == ST_MID); // R10
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LWRITE && cyc_end) |=> (idle && done)); // R13
    AST_READ_AFTER_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_INVAL && !boff) |=> r_q.state == ST_LREAD); // R4

endmodule

// File: rtl/lrmw_lock_ctl.sv
module lrmw_lock_ctl
    import lrmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_next,
    input  logic wt_mode,
    input  logic hold_req,
    input  logic idle,
    input  logic req_take,
    output logic lock_q,
    output logic mcl_n_q,
    output logic hold_ack_q
);
    lock_regs_t r_q, r_d;

    always_comb begin
        r_d          = r_q;
        r_d.lock     = lock_next;
        r_d.mcl_n    = !(lock_next && wt_mode);
        r_d.hold_ack = hold_req && idle && !req_take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{lock: 1'b0, mcl_n: 1'b1, hold_ack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign lock_q     = r_q.lock;
    assign mcl_n_q    = r_q.mcl_n;
    assign hold_ack_q = r_q.hold_ack;

    AST_NO_HOLD_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.lock |-> !r_q.hold_ack); // R8
    AST_WB_MCL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wt_mode && !$past(wt_mode)) |-> r_q.mcl_n); // R7

endmodule

// File: rtl/locked_rmw_seq.sv
module locked_rmw_seq
    import lrmw_pkg::*;
#(
    parameter int LINE_BEATS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       lookup_hit,
    input  logic       lookup_dirty,
    input  logic       wbuf_empty,
    input  logic       wr_go,
    input  logic       snoop_wb,
    input  logic       bus_rdy,
    input  logic       bus_brdy,
    input  logic       hold_req,
    input  logic       boff,
    input  logic       ahold,
    input  logic       wt_mode,
    output logic       cmd_valid,
    output logic [1:0] cmd_op,
    output logic       cmd_burst,
    output logic       bus_lock,
    output logic       mc_lock_n,
    output logic       hold_ack,
    output logic       busy,
    output logic       seq_done
);
    logic cyc_end, bus_active, req_take, idle, lock_next;

    lrmw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .lookup_hit  (lookup_hit),
        .lookup_dirty(lookup_dirty),
        .wbuf_empty  (wbuf_empty),
        .wr_go       (wr_go),
        .snoop_wb    (snoop_wb),
        .boff        (boff),
        .ahold       (ahold),
        .hold_ack_q  (hold_ack),
        .cyc_end     (cyc_end),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_burst   (cmd_burst),
        .bus_active  (bus_active),
        .req_take    (req_take),
        .idle        (idle),
        .lock_next   (lock_next),
        .busy        (busy),
        .done        (seq_done)
    );

    lrmw_beat_ctr #(.LINE_BEATS(LINE_BEATS)) u_beats (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (bus_active),
        .burst  (cmd_burst),
        .rdy    (bus_rdy),
        .brdy   (bus_brdy),
        .cyc_end(cyc_end)
    );

    lrmw_lock_ctl u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_next (lock_next),
        .wt_mode   (wt_mode),
        .hold_req  (hold_req),
        .idle      (idle),
        .req_take  (req_take),
        .lock_q    (bus_lock),
        .mcl_n_q   (mc_lock_n),
        .hold_ack_q(hold_ack)
    );

    AST_CPBK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_COPYBACK && !bus_lock) |-> !busy == 1'b0); // R5
    AST_LOCK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> busy); // R13

endmodule

// File: tb/locked_rmw_seq_bench.sv
module locked_rmw_seq_bench;
    localparam int BEATS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, lookup_hit = 0, lookup_dirty = 0, wbuf_empty = 1;
    logic wr_go = 0, snoop_wb = 0, bus_rdy = 0, bus_brdy = 0;
    logic hold_req = 0, boff = 0, ahold = 0, wt_mode = 1;
    logic cmd_valid, cmd_burst, bus_lock, mc_lock_n, hold_ack, busy, seq_done;
    logic [1:0] cmd_op;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    locked_rmw_seq #(.LINE_BEATS(BEATS)) u_locked_rmw_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lookup_hit(lookup_hit),
        .lookup_dirty(lookup_dirty), .wbuf_empty(wbuf_empty), .wr_go(wr_go),
        .snoop_wb(snoop_wb), .bus_rdy(bus_rdy), .bus_brdy(bus_brdy),
        .hold_req(hold_req), .boff(boff), .ahold(ahold), .wt_mode(wt_mode),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_burst(cmd_burst),
        .bus_lock(bus_lock), .mc_lock_n(mc_lock_n), .hold_ack(hold_ack),
        .busy(busy), .seq_done(seq_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic start_req(input logic hit, input logic dirty);
        req_valid = 1; lookup_hit = hit; lookup_dirty = dirty;
        tick();
        req_valid = 0; lookup_hit = 0; lookup_dirty = 0;
    endtask

    task automatic expect_cmd(input string req, input int op);
        for (int i = 0; i < 20 && !cmd_valid; i++) tick();
        chk(req, "cmd_valid", int'(cmd_valid), 1);
        chk(req, "cmd_op", int'(cmd_op), op);
    endtask

    task automatic give_rdy();
        bus_rdy = 1; tick(); bus_rdy = 0;
    endtask

    task automatic give_brdy();
        bus_brdy = 1; tick(); bus_brdy = 0;
    endtask

    // Locked read then locked write; ends one cycle after the final ready.
    task automatic finish_rw(input string req);
        expect_cmd(req, 2);
        give_rdy();
        wr_go = 1;
        expect_cmd(req, 3);
        wr_go = 0;
        give_brdy();
        chk(req, "bus_lock after final ready", int'(bus_lock), 0);
    endtask

    task automatic t_reset();
        chk("R1", "cmd_valid", int'(cmd_valid), 0);
        chk("R1", "bus_lock", int'(bus_lock), 0);
        chk("R1", "mc_lock_n", int'(mc_lock_n), 1);
        chk("R1", "hold_ack", int'(hold_ack), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "seq_done", int'(seq_done), 0);
    endtask

    task automatic t_miss_wt();
        wt_mode = 1;
        start_req(0, 0);
        expect_cmd("R3", 2);
        chk("R6", "lock with first read", int'(bus_lock), 1);
        chk("R7", "mc_lock_n low in write-through", int'(mc_lock_n), 0);
        give_rdy();
        chk("R3", "no command before wr_go", int'(cmd_valid), 0);
        chk("R6", "lock held between", int'(bus_lock), 1);
        wr_go = 1;
        expect_cmd("R3", 3);
        wr_go = 0;
        chk("R6", "lock during write", int'(bus_lock), 1);
        give_brdy();
        chk("R6", "lock released", int'(bus_lock), 0);
        chk("R7", "mc_lock_n released", int'(mc_lock_n), 1);
        chk("R13", "busy low after release", int'(busy), 0);
        chk("R13", "done pulse", int'(seq_done), 1);
        tick();
        chk("R13", "done one cycle", int'(seq_done), 0);
    endtask

    task automatic t_hit_clean_wb();
        wt_mode = 0;
        start_req(1, 0);
        expect_cmd("R4", 1);
        chk("R7", "mc_lock_n high in write-back", int'(mc_lock_n), 1);
        tick();
        expect_cmd("R4", 2);
        chk("R7", "mc_lock_n high while locked", int'(mc_lock_n), 1);
        chk("R6", "lock in write-back mode", int'(bus_lock), 1);
        give_rdy();
        wr_go = 1;
        expect_cmd("R4", 3);
        wr_go = 0;
        give_rdy();
        tick();
        wt_mode = 1;
    endtask

    task automatic t_hit_dirty();
        start_req(1, 1);
        expect_cmd("R5", 0);
        chk("R5", "copy-back is burst", int'(cmd_burst), 1);
        chk("R5", "copy-back unlocked", int'(bus_lock), 0);
        for (int b = 0; b < BEATS - 1; b++) give_brdy();
        chk("R5", "still copy-back before last beat", int'(cmd_op), 0);
        give_brdy();
        expect_cmd("R5", 1);
        tick();
        finish_rw("R5");
        tick();
    endtask

    task automatic t_drain();
        wbuf_empty = 0;
        start_req(0, 0);
        for (int i = 0; i < 5; i++) begin
            chk("R2", "no command while draining", int'(cmd_valid), 0);
            chk("R2", "busy while draining", int'(busy), 1);
            tick();
        end
        wbuf_empty = 1;
        finish_rw("R2");
        tick();
    endtask

    task automatic t_hold();
        hold_req = 1;
        tick();
        chk("R8", "hold granted when idle", int'(hold_ack), 1);
        req_valid = 1;
        tick(); tick();
        req_valid = 0;
        chk("R8", "no request taken under hold", int'(busy), 0);
        hold_req = 0;
        tick();
        chk("R8", "hold dropped", int'(hold_ack), 0);
        start_req(0, 0);
        expect_cmd("R8", 2);
        hold_req = 1;
        give_rdy();
        tick(); tick();
        chk("R8", "hold ignored in lock", int'(hold_ack), 0);
        wr_go = 1;
        expect_cmd("R8", 3);
        wr_go = 0;
        give_rdy();
        chk("R8", "lock just released", int'(bus_lock), 0);
        chk("R8", "hold not yet granted", int'(hold_ack), 0);
        tick();
        chk("R8", "hold granted after release", int'(hold_ack), 1);
        hold_req = 0;
        tick(); tick();
    endtask

    task automatic t_boff();
        start_req(1, 1);
        expect_cmd("R9", 0);
        give_brdy(); give_brdy();
        boff = 1;
        tick();
        chk("R9", "no command in back-off", int'(cmd_valid), 0);
        bus_brdy = 1;
        tick();
        bus_brdy = 0; boff = 0;
        tick();
        expect_cmd("R9", 0);
        for (int b = 0; b < BEATS - 1; b++) give_brdy();
        chk("R9", "burst replayed from first beat", int'(cmd_op), 0);
        give_brdy();
        expect_cmd("R9", 1);
        tick();
        expect_cmd("R9", 2);
        boff = 1;
        tick();
        chk("R9", "lock kept in back-off", int'(bus_lock), 1);
        chk("R9", "read withdrawn", int'(cmd_valid), 0);
        boff = 0;
        tick();
        finish_rw("R9");
        tick();
    endtask

    task automatic t_ahold_snoop();
        start_req(0, 0);
        expect_cmd("R10", 2);
        give_rdy();
        ahold = 1; wr_go = 1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R10", "held by ahold", int'(cmd_valid), 0);
        end
        ahold = 0; snoop_wb = 1;
        tick();
        chk("R11", "snoop copy-back first", int'(cmd_op), 0);
        chk("R11", "snoop command valid", int'(cmd_valid), 1);
        chk("R11", "lock held in snoop", int'(bus_lock), 1);
        snoop_wb = 0;
        give_brdy();
        chk("R12", "burst continues", int'(cmd_op), 0);
        give_rdy();
        chk("R12", "rdy ends burst early", int'(cmd_valid), 0);
        expect_cmd("R11", 3);
        wr_go = 0;
        give_rdy();
        chk("R11", "released after write", int'(bus_lock), 0);
        tick();
    endtask

    initial begin
        for (int i = 0; i < 20000 && !finished; i++) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_miss_wt();
        t_hit_clean_wb();
        t_hit_dirty();
        t_drain();
        t_hold();
        t_boff();
        t_ahold_snoop();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule